// File: doc/BRIEF.md
# Signaling PCM Stream Formatter

This block turns per-channel signaling state into a serial stream that runs alongside the received channel timeslots. For every channel position of every frame it shifts out one 8-bit slot, most significant bit first. The first four bits of the slot are zero and the last four carry that channel's signaling bits. A framing counter drives the block with the current channel index and bit index, one bit per clock. The bits go out on `sig_out` with a fixed delay of one clock.

Capture logic upstream writes the signaling values it recovers into a staging store, one channel at a time. The block does not put these values on the stream straight away. Once per multiframe it copies the whole staging store into an output buffer, and the stream always reads from that buffer. So the stream changes only on multiframe boundaries:

- every 24 frames in extended-superframe mode;
- every 12 frames in superframe mode;
- every 16 frames in 32-channel CAS mode.

An external multiframe strobe sets where the boundary falls. A freeze input can block the copy, so the stream keeps its previous signaling values. In superframe mode only two signaling bits exist, and they are sent twice to fill the four-bit field.

Top module: `sig_pcm_formatter`

## Requirements
- R1: While reset is asserted, and after it is released, `sig_out` is 0. The staging store and the output buffer both start at zero, so the stream carries only zeros until the first refresh.
- R2: For slot bit positions 0 to 3 (`bit_idx` 0..3, the first four bits sent), `sig_out` is 0.
- R3: When `mode` is 2'b00 (extended superframe), 2'b10 (32-channel CAS) or 2'b11 (handled as CAS), slot bit positions 4, 5, 6 and 7 carry the buffered bits A, B, C, D. These are `cap_sig[3]`, `cap_sig[2]`, `cap_sig[1]` and `cap_sig[0]` as they were written for that channel.
- R4: When `mode` is 2'b01 (superframe), slot bit positions 4..7 carry A, B, A, B. Position 6 repeats position 4, and position 7 repeats position 5.
- R5: `sig_out` shows the bit for the channel and bit position presented on the previous clock, which is a latency of exactly one cycle.
- R6: Writes to the staging store (`cap_we`, `cap_ch`, `cap_sig`) have no effect on `sig_out` until the next refresh.
- R7: A frame starts at `ch_idx`=0 with `bit_idx`=0. The frame that starts a multiframe causes a refresh, and a refresh copies the staging store into the output buffer. The multiframe is 24 frames in mode 2'b00, 12 frames in mode 2'b01, and 16 frames in modes 2'b10 and 2'b11.
- R8: `mf_sync` refreshes the buffer in the cycle it is high and restarts the frame count. The next refresh from the count comes one multiframe length of frame starts later.
- R9: If `freeze` is high in a refresh cycle, the output buffer keeps its contents and the stream repeats the previous values.
- R10: A channel index of `NUM_CH` or more produces an all-zero slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 extended superframe, 01 superframe, 10/11 32-channel CAS |
| ch_idx | input | CH_IDX_W | Channel timeslot of the current bit |
| bit_idx | input | 3 | Bit position within the slot, 0 is sent first |
| mf_sync | input | 1 | Multiframe strobe, high at the first bit of a multiframe |
| freeze | input | 1 | Blocks buffer refresh while high |
| cap_we | input | 1 | Staging write strobe |
| cap_ch | input | CH_IDX_W | Channel being written |
| cap_sig | input | 4 | Captured bits A,B,C,D in bits 3..0 |
| sig_out | output | 1 | Serial signaling stream |

## Verification
The hardest case to reach from the ports is a refresh that comes from the frame counter alone, with no strobe. It only happens after a full 12, 16 or 24 frames with staging values that differ from the buffered ones. To reach it, the bench writes fresh staging values right after each strobed refresh. It then plays complete frames until the counter wraps, and checks every slot along the way: the old values must hold until the wrap and the new ones appear at it. A strobe in the middle of a multiframe and a strobe while frozen are reached the same way, by counting frames in the bench.

// File: rtl/sig_pcm_formatter.sv
module sig_pcm_formatter #(
  parameter int NUM_CH   = 32,
  parameter int CH_IDX_W = 6,
  parameter int LEN_ESF  = 24,
  parameter int LEN_SF   = 12,
  parameter int LEN_CAS  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [CH_IDX_W-1:0] ch_idx,
  input  logic [2:0]          bit_idx,
  input  logic                mf_sync,
  input  logic                freeze,
  input  logic                cap_we,
  input  logic [CH_IDX_W-1:0] cap_ch,
  input  logic [3:0]          cap_sig,
  output logic                sig_out
);

  localparam int MAX_LEN = (LEN_ESF > LEN_SF) ? ((LEN_ESF > LEN_CAS) ? LEN_ESF : LEN_CAS)
                                              : ((LEN_SF > LEN_CAS) ? LEN_SF : LEN_CAS);
  localparam int FCNT_W  = $clog2(MAX_LEN + 1);
  localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][3:0] stage_q;
  logic [NUM_CH-1:0][3:0] buf_q;
  logic [FCNT_W-1:0]      fcnt_q;
  logic [FCNT_W-1:0]      cur_len;
  logic                   sf_mode;
  logic                   frame_start;
  logic                   wrap;
  logic                   refresh;
  logic                   ch_ok;
  logic [3:0]             sel;
  logic                   nib_bit;
  logic                   sig_q;

  always_comb begin
    case (mode)
      2'b00:   cur_len = FCNT_W'(LEN_ESF);
      2'b01:   cur_len = FCNT_W'(LEN_SF);
      default: cur_len = FCNT_W'(LEN_CAS);
    endcase
  end

  assign sf_mode     = (mode == 2'b01);
  assign frame_start = (ch_idx == '0) && (bit_idx == 3'd0);
  assign wrap        = frame_start && (fcnt_q >= cur_len - FCNT_W'(1));
  assign refresh     = mf_sync || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)
      fcnt_q <= '0;
    else if (refresh)
      fcnt_q <= '0;
    else if (frame_start)
      fcnt_q <= fcnt_q + FCNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (cap_we && (32'(cap_ch) < NUM_CH)) begin
      stage_q[cap_ch[SEL_W-1:0]] <= cap_sig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      buf_q <= '0;
    else if (refresh && !freeze)
      buf_q <= stage_q;
  end

  assign ch_ok = (32'(ch_idx) < NUM_CH);
  assign sel   = buf_q[ch_idx[SEL_W-1:0]];

  always_comb begin
    case (bit_idx[1:0])
      2'd0:    nib_bit = sel[3];
      2'd1:    nib_bit = sel[2];
      2'd2:    nib_bit = sf_mode ? sel[3] : sel[1];
      default: nib_bit = sf_mode ? sel[2] : sel[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sig_q <= 1'b0;
    else
      sig_q <= ch_ok && bit_idx[2] && nib_bit;
  end

  assign sig_out = sig_q;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx < 3'd4) |=> !sig_out);

  assert_bad_channel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_ok |=> !sig_out);

  assert_hold_between_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(buf_q));

  assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(buf_q));

  assert_sync_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_sync && !freeze) |=> (buf_q == $past(stage_q)));

  assert_count_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (fcnt_q == '0));

endmodule

// File: tb/tb_sig_pcm_formatter.sv
module tb_sig_pcm_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] ch_idx = 6'd63;
  logic [2:0] bit_idx = 3'd0;
  logic       mf_sync = 1'b0;
  logic       freeze = 1'b0;
  logic       cap_we = 1'b0;
  logic [5:0] cap_ch = 6'd0;
  logic [3:0] cap_sig = 4'd0;
  logic       sig_out;

  int checks = 0;
  int errors = 0;

  logic [3:0] exp_stage [NCH];
  logic [3:0] exp_buf   [NCH];
  int         tb_fcnt = 0;

  logic  prev_valid = 1'b0;
  logic  prev_exp = 1'b0;
  int    prev_ch = 0;
  int    prev_b = 0;
  string prev_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_pcm_formatter dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ch_idx(ch_idx), .bit_idx(bit_idx),
    .mf_sync(mf_sync), .freeze(freeze), .cap_we(cap_we), .cap_ch(cap_ch),
    .cap_sig(cap_sig), .sig_out(sig_out)
  );

  function automatic int mf_len(logic [1:0] m);
    if (m == 2'b00) return 24;
    if (m == 2'b01) return 12;
    return 16;
  endfunction

  function automatic logic expect_bit(int ch, int b);
    logic [3:0] v;
    if (ch >= NCH || b < 4) return 1'b0;
    v = exp_buf[ch];
    case (b)
      4: return v[3];
      5: return v[2];
      6: return (mode == 2'b01) ? v[3] : v[1];
      default: return (mode == 2'b01) ? v[2] : v[0];
    endcase
  endfunction

  task automatic check(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic flush_check();
    string t;
    if (prev_valid) begin
      // R5: the bit for the previous cycle's position is compared here
      t = (prev_b < 4) ? "R2 upper nibble" : prev_tag;
      t = $sformatf("%s (R5 slot ch %0d bit %0d)", t, prev_ch, prev_b);
      check(t, sig_out, prev_exp);
      prev_valid = 1'b0;
    end
  endtask

  task automatic drive_slot(int ch, int b, logic sync, string tag);
    @(negedge clk);
    flush_check();
    ch_idx = 6'(ch);
    bit_idx = 3'(b);
    mf_sync = sync;
    prev_exp = expect_bit(ch, b);
    prev_ch = ch;
    prev_b = b;
    prev_tag = tag;
    prev_valid = 1'b1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    flush_check();
    ch_idx = 6'd63;
    bit_idx = 3'd0;
    mf_sync = 1'b0;
  endtask

  task automatic send_frame(int nch, logic sync, logic extra, string tag);
    logic refresh;
    int   len;
    len = mf_len(mode);
    refresh = sync || (tb_fcnt >= len - 1);
    if (refresh) tb_fcnt = 0;
    else tb_fcnt++;
    if (refresh && !freeze)
      for (int i = 0; i < NCH; i++) exp_buf[i] = exp_stage[i];
    for (int ch = 0; ch < nch; ch++)
      for (int b = 0; b < 8; b++)
        drive_slot(ch, b, sync && ch == 0 && b == 0, tag);
    if (extra)
      for (int ch = NCH; ch < NCH + 4; ch++)
        for (int b = 0; b < 8; b++)
          drive_slot(ch, b, 1'b0, "R10 out-of-range channel");
    go_idle();
  endtask

  task automatic cap_write(int ch, logic [3:0] v);
    @(negedge clk);
    flush_check();
    cap_we = 1'b1;
    cap_ch = 6'(ch);
    cap_sig = v;
    exp_stage[ch] = v;
    @(negedge clk);
    cap_we = 1'b0;
  endtask

  task automatic fill_stage(int nch, int mul, int add);
    for (int ch = 0; ch < nch; ch++) cap_write(ch, 4'((ch * mul + add) & 15));
  endtask

  task automatic test_reset();
    for (int i = 0; i < NCH; i++) begin
      exp_stage[i] = 4'd0;
      exp_buf[i] = 4'd0;
    end
    repeat (3) @(negedge clk);
    check("R1 output during reset", sig_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 output after reset", sig_out, 1'b0);
    send_frame(24, 1'b0, 1'b0, "R1 zero buffer after reset");
  endtask

  task automatic test_esf();
    mode = 2'b00;
    fill_stage(24, 7, 5);
    send_frame(24, 1'b1, 1'b0, "R3 ESF nibble");
    fill_stage(24, 3, 9);
    for (int f = 0; f < 23; f++) send_frame(24, 1'b0, 1'b0, "R6 ESF hold until boundary");
    send_frame(24, 1'b0, 1'b0, "R7 ESF 24-frame refresh");
  endtask

  task automatic test_sf();
    mode = 2'b01;
    fill_stage(24, 5, 2);
    send_frame(24, 1'b1, 1'b0, "R4 SF duplicated AB");
    fill_stage(24, 11, 7);
    for (int f = 0; f < 11; f++) send_frame(24, 1'b0, 1'b0, "R6 SF hold until boundary");
    send_frame(24, 1'b0, 1'b0, "R7 SF 12-frame refresh");
  endtask

  task automatic test_cas();
    mode = 2'b10;
    fill_stage(NCH, 9, 1);
    send_frame(NCH, 1'b1, 1'b1, "R3 CAS nibble");
    fill_stage(NCH, 13, 4);
    for (int f = 0; f < 15; f++) send_frame(NCH, 1'b0, 1'b0, "R6 CAS hold until boundary");
    send_frame(NCH, 1'b0, 1'b1, "R7 CAS 16-frame refresh");
  endtask

  task automatic test_freeze();
    mode = 2'b11;
    fill_stage(NCH, 6, 3);
    freeze = 1'b1;
    send_frame(NCH, 1'b1, 1'b0, "R9 freeze keeps old values");
    freeze = 1'b0;
    send_frame(NCH, 1'b1, 1'b0, "R8 strobe after freeze release");
  endtask

  task automatic test_resync();
    mode = 2'b00;
    fill_stage(24, 1, 8);
    send_frame(24, 1'b1, 1'b0, "R8 strobe load");
    for (int f = 0; f < 5; f++) send_frame(24, 1'b0, 1'b0, "R6 mid-multiframe hold");
    fill_stage(24, 15, 6);
    send_frame(24, 1'b1, 1'b0, "R8 mid-multiframe strobe");
    fill_stage(24, 4, 11);
    for (int f = 0; f < 23; f++) send_frame(24, 1'b0, 1'b0, "R8 count restarted hold");
    send_frame(24, 1'b0, 1'b0, "R8 count restarted refresh");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_esf();
    test_sf();
    test_cas();
    test_freeze();
    test_resync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule